// File: doc/BRIEF.md
# Dual-Channel Serial Frequency Word Transmitter

This block takes a 40-bit frequency control word for each of two independent channels and sends it out one bit at a time, most significant bit first, on a per-channel data pin. A per-channel sync pin is driven to its active level for the period that carries the first bit of each word. Each channel transmits only the upper part of its word. The length of that part is one of eight values, picked by a 3-bit code. The sync level that marks a word is set separately for each channel.

Both channels share one serial clock output. It runs at the system clock rate, or at a divided rate of 2, 4, 8 or 16 system clocks per bit. A configuration bit sets which edge of the serial clock the data changes on. Data always changes on the edge the receiver does not sample, so the receiver samples on the other edge. A load strobe that arrives while a word is still being sent is held. The held word starts in the period right after the last bit of the current word. Configuration inputs are meant to be changed only while reset is asserted.

Top module: `freq_word_serializer`

## Requirements
- R1: Width code c (0 to 7) selects a word length of 8, 12, 16, 20, 24, 28, 32 or 40 bits, in that order. The bits sent are word[39] down to word[40-length].
- R2: Bits go out most significant first, one bit per serial period, and each bit holds its level for the whole period.
- R3: Sync sits at its active level for exactly the one serial period that carries the first bit of a word, and at its inactive level at all other times. The active level is high when the channel's sync-high bit is 1 and low when it is 0.
- R4: The two channels run independently. A load, width, sync level or word on one channel has no effect on the other channel's outputs.
- R5: With the divided clock off, a serial period is one system clock. With it on, a period is 2, 4, 8 or 16 system clocks for rate codes 0, 1, 2 and 3. The first period after reset begins at the first clock after reset ends.
- R6: With the invert bit at 0, the serial clock is low in the first half of each period and high in the second half. Data and sync change at the falling edge. At the full rate the serial clock is the inverse of the system clock. The invert bit at 1 inverts the serial clock.
- R7: A load that arrives while a word is being sent is held. The held word starts in the period right after the current word's last bit, with no gap. A second load before the held word starts replaces it.
- R8: During reset and whenever no word is being sent, data is 0 and sync is at its inactive level.
- R9: A load sampled at a clock edge while the channel is idle starts its first bit at the first period boundary after that edge. At the full rate, this is the next clock edge.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_slow_en | input | 1 | Turns on the divided serial clock |
| cfg_rate | input | 2 | Divide code: 2, 4, 8 or 16 clocks per bit |
| cfg_clk_inv | input | 1 | Inverts the serial clock relative to the data |
| cfg_width_a | input | 3 | Word length code, channel A |
| cfg_sync_hi_a | input | 1 | Sync active level, channel A (1 means high) |
| load_a | input | 1 | Load strobe, channel A |
| word_a | input | 40 | Frequency word, channel A |
| cfg_width_b | input | 3 | Word length code, channel B |
| cfg_sync_hi_b | input | 1 | Sync active level, channel B |
| load_b | input | 1 | Load strobe, channel B |
| word_b | input | 40 | Frequency word, channel B |
| ser_clk | output | 1 | Shared serial clock |
| ser_data_a | output | 1 | Serial data, channel A |
| ser_sync_a | output | 1 | Word sync, channel A |
| ser_data_b | output | 1 | Serial data, channel B |
| ser_sync_b | output | 1 | Word sync, channel B |

## Verification
Data and sync come from registers that update only at period boundaries, so every result appears in the clock cycle just after the boundary edge. For an idle channel at the full rate, a load sampled at edge k puts the first bit on the pins after edge k+1. At a divided rate it waits for the divider to wrap. The bench's reference model steps a divider count and a per-channel bits-remaining count at each rising edge, with no latency of its own. It compares data, sync and the serial clock one nanosecond after every rising edge, once the registers have settled, so each expected value is checked in the exact cycle it is due.

// File: rtl/fws_pkg.sv
package fws_pkg;

  localparam int FWS_WORD_W = 40;
  localparam int FWS_CODE_W = 3;
  localparam int FWS_RATE_W = 2;
  localparam int FWS_LEN_W  = $clog2(FWS_WORD_W + 1);

  typedef logic [FWS_LEN_W-1:0] fws_len_t;

  typedef struct packed {
    logic [FWS_CODE_W-1:0] width_code;
    logic                  sync_hi;
  } fws_ch_cfg_t;

  // Word length for a width code: steps of four from 8, top code is 40.
  function automatic fws_len_t fws_code_to_len(input logic [FWS_CODE_W-1:0] code);
    fws_len_t len;
    if (code == '1) len = fws_len_t'(FWS_WORD_W);
    else            len = fws_len_t'(8 + 4 * int'(code));
    return len;
  endfunction

endpackage

// File: rtl/fws_rate_gen.sv
module fws_rate_gen #(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_en,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              clk_inv,
  output logic              tick_o,
  output logic              ser_clk_o
);
  localparam int DIV_W = 2 ** RATE_W;

  logic [DIV_W:0]   period;
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_nxt;
  logic             tick;
  logic             sclk_q;

  always_comb begin
    period = (DIV_W+1)'(2) << rate_code;
    lim    = DIV_W'(period - 1'b1);
    half   = DIV_W'(period >> 1);
    tick   = !slow_en || (cnt_q >= lim);
    if (!slow_en)  cnt_nxt = '0;
    else if (tick) cnt_nxt = '0;
    else           cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sclk_q <= clk_inv;
    end else begin
      cnt_q  <= cnt_nxt;
      sclk_q <= clk_inv ^ (cnt_nxt >= half);
    end
  end

  assign tick_o    = tick;
  assign ser_clk_o = slow_en ? sclk_q : (~clk ^ clk_inv);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    (slow_en && tick) |=> !tick);  // R5

  AST_PERIOD_STARTS_LOW: assert property (@(posedge clk) disable iff (rst)
    (slow_en && tick) |=> (sclk_q == clk_inv));  // R6

endmodule

// File: rtl/fws_channel.sv
module fws_channel
  import fws_pkg::*;
#(
  parameter int WORD_W = FWS_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  fws_ch_cfg_t       cfg,
  output logic              data_o,
  output logic              sync_o
);
  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] held_word_q;
  logic              held_q;
  fws_len_t          left_q;
  logic              data_q;
  logic              sync_q;
  logic              more_bits;

  assign more_bits = (left_q > fws_len_t'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q     <= '0;
      held_word_q <= '0;
      held_q      <= 1'b0;
      left_q      <= '0;
      data_q      <= 1'b0;
      sync_q      <= ~cfg.sync_hi;
    end else begin
      if (tick) begin
        if (more_bits) begin
          shreg_q <= shreg_q << 1;
          left_q  <= left_q - 1'b1;
          data_q  <= shreg_q[WORD_W-2];
          sync_q  <= ~cfg.sync_hi;
        end else if (held_q) begin
          shreg_q <= held_word_q;
          left_q  <= fws_code_to_len(cfg.width_code);
          data_q  <= held_word_q[WORD_W-1];
          sync_q  <= cfg.sync_hi;
        end else begin
          left_q  <= '0;
          data_q  <= 1'b0;
          sync_q  <= ~cfg.sync_hi;
        end
      end
      // A new load wins over consumption of the held word.
      if (load) begin
        held_q      <= 1'b1;
        held_word_q <= word;
      end else if (tick && !more_bits) begin
        held_q <= 1'b0;
      end
    end
  end

  assign data_o = data_q;
  assign sync_o = sync_q;

  AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    left_q <= fws_len_t'(WORD_W));  // R1

  AST_SYNC_ONE_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (tick && (sync_q == cfg.sync_hi)) |=> (sync_q != cfg.sync_hi));  // R3

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(data_q) && $stable(sync_q)));  // R2

  AST_HELD_KEPT: assert property (@(posedge clk) disable iff (rst)
    (held_q && !tick) |=> held_q);  // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (left_q == '0) |-> (!data_q && (sync_q != cfg.sync_hi)));  // R8

endmodule

// File: rtl/freq_word_serializer.sv
module freq_word_serializer
  import fws_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_slow_en,
  input  logic [FWS_RATE_W-1:0] cfg_rate,
  input  logic                  cfg_clk_inv,
  input  logic [FWS_CODE_W-1:0] cfg_width_a,
  input  logic                  cfg_sync_hi_a,
  input  logic                  load_a,
  input  logic [FWS_WORD_W-1:0] word_a,
  input  logic [FWS_CODE_W-1:0] cfg_width_b,
  input  logic                  cfg_sync_hi_b,
  input  logic                  load_b,
  input  logic [FWS_WORD_W-1:0] word_b,
  output logic                  ser_clk,
  output logic                  ser_data_a,
  output logic                  ser_sync_a,
  output logic                  ser_data_b,
  output logic                  ser_sync_b
);
  localparam int NUM_CH = 2;

  logic                  tick;
  logic                  load_v [NUM_CH];
  logic [FWS_WORD_W-1:0] word_v [NUM_CH];
  fws_ch_cfg_t           cfg_v  [NUM_CH];
  logic                  data_v [NUM_CH];
  logic                  sync_v [NUM_CH];

  assign load_v[0] = load_a;
  assign load_v[1] = load_b;
  assign word_v[0] = word_a;
  assign word_v[1] = word_b;
  assign cfg_v[0]  = '{width_code: cfg_width_a, sync_hi: cfg_sync_hi_a};
  assign cfg_v[1]  = '{width_code: cfg_width_b, sync_hi: cfg_sync_hi_b};

  fws_rate_gen #(.RATE_W(FWS_RATE_W)) rate_i (
    .clk       (clk),
    .rst       (rst),
    .slow_en   (cfg_slow_en),
    .rate_code (cfg_rate),
    .clk_inv   (cfg_clk_inv),
    .tick_o    (tick),
    .ser_clk_o (ser_clk)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    fws_channel #(.WORD_W(FWS_WORD_W)) ch_i (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .load   (load_v[g]),
      .word   (word_v[g]),
      .cfg    (cfg_v[g]),
      .data_o (data_v[g]),
      .sync_o (sync_v[g])
    );
  end

  assign ser_data_a = data_v[0];
  assign ser_sync_a = sync_v[0];
  assign ser_data_b = data_v[1];
  assign ser_sync_b = sync_v[1];

endmodule

// File: tb/freq_word_serializer_tb_top.sv
module freq_word_serializer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow = 1'b0;
  logic [1:0]  rate = 2'd0;
  logic        inv = 1'b0;
  logic [2:0]  wcode [2];
  logic        pol   [2];
  logic        ld    [2];
  logic [39:0] wd    [2];
  logic        sclk, da, sa, db, sb;

  freq_word_serializer dut_i (
    .clk(clk), .rst(rst), .cfg_slow_en(slow), .cfg_rate(rate), .cfg_clk_inv(inv),
    .cfg_width_a(wcode[0]), .cfg_sync_hi_a(pol[0]), .load_a(ld[0]), .word_a(wd[0]),
    .cfg_width_b(wcode[1]), .cfg_sync_hi_b(pol[1]), .load_b(ld[1]), .word_b(wd[1]),
    .ser_clk(sclk), .ser_data_a(da), .ser_sync_a(sa), .ser_data_b(db), .ser_sync_b(sb)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cycles  = 0;
  bit    done    = 0;
  string tag     = "R8_reset";

  // Behavioural reference model
  int          m_cnt;
  int          m_left [2];
  int          m_len  [2];
  logic [39:0] m_word [2];
  logic [39:0] m_held_w [2];
  bit          m_held [2];
  logic        e_data [2];
  logic        e_sync [2];
  logic        e_sclk;

  function automatic int len_of(input logic [2:0] c);
    return (c == 3'd7) ? 40 : 8 + 4 * int'(c);
  endfunction

  always @(posedge clk) begin
    int  per;
    bit  tk;
    if (rst) begin
      m_cnt = 0;
      e_sclk = inv;
      for (int c = 0; c < 2; c++) begin
        m_left[c] = 0; m_held[c] = 0; e_data[c] = 0; e_sync[c] = ~pol[c];
      end
    end else begin
      per = 2 << rate;
      tk  = !slow || (m_cnt == per - 1);
      m_cnt = (!slow || tk) ? 0 : m_cnt + 1;
      for (int c = 0; c < 2; c++) begin
        if (tk) begin
          if (m_left[c] > 1) begin
            m_left[c]--;
            e_data[c] = m_word[c][39 - (m_len[c] - m_left[c])];
            e_sync[c] = ~pol[c];
          end else if (m_held[c]) begin
            m_word[c] = m_held_w[c];
            m_len[c]  = len_of(wcode[c]);
            m_left[c] = m_len[c];
            e_data[c] = m_word[c][39];
            e_sync[c] = pol[c];
            m_held[c] = 0;
          end else begin
            m_left[c] = 0; e_data[c] = 0; e_sync[c] = ~pol[c];
          end
        end
        if (ld[c]) begin m_held[c] = 1; m_held_w[c] = wd[c]; end
      end
      e_sclk = slow ? (inv ^ (m_cnt >= (per / 2))) : inv;
    end
  end

  task automatic chk(input logic got, input logic exp, input string what);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b (t=%0t)", tag, what, got, exp, $time);
    end
  endtask

  // Samples 1 ns after each rising edge, when all registers have settled.
  task automatic compare_all();
    chk(da, e_data[0], "chA data (R2)");
    chk(sa, e_sync[0], "chA sync (R3)");
    chk(db, e_data[1], "chB data (R4)");
    chk(sb, e_sync[1], "chB sync (R4)");
    chk(sclk, e_sclk, "serial clock (R6)");
  endtask

  initial begin
    forever begin
      #2 clk = 1'b1;
      #1 if (!done) compare_all();
      #1 clk = 1'b0;
      cycles++;
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    wait (cycles > 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    summary();
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input bit s, input logic [1:0] r, input bit iv,
                          input logic [2:0] wa, input logic [2:0] wb,
                          input bit pa, input bit pb);
    @(negedge clk);
    rst = 1; slow = s; rate = r; inv = iv;
    wcode[0] = wa; wcode[1] = wb; pol[0] = pa; pol[1] = pb;
    ld[0] = 0; ld[1] = 0;
    wait_cyc(3);
    rst = 0;
  endtask

  task automatic load(input bit a, input bit b);
    @(negedge clk);
    ld[0] = a; ld[1] = b;
    wd[0] = {$urandom, $urandom} ; wd[1] = {$urandom, $urandom};
    @(negedge clk);
    ld[0] = 0; ld[1] = 0;
  endtask

  initial begin
    wd[0] = '0; wd[1] = '0;
    ld[0] = 0; ld[1] = 0;
    // R8: reset state with mixed sync levels
    do_reset(0, 2'd0, 0, 3'd0, 3'd7, 1'b1, 1'b0);
    @(posedge clk); #1;
    tag = "R8_reset_state";
    chk(da, 1'b0, "chA idle data");
    chk(sa, 1'b0, "chA idle sync");
    chk(db, 1'b0, "chB idle data");
    chk(sb, 1'b1, "chB idle sync");
    @(negedge clk);

    // R1, R4, R9: every width code on both channels, full rate
    for (int c = 0; c < 8; c++) begin
      tag = $sformatf("R1_R9_full_rate_code_%0d", c);
      do_reset(0, 2'd0, c[0], 3'(c), 3'(7 - c), c[1], ~c[1]);
      load(1, 1);
      wait_cyc(45);
      load(1, 0);
      wait_cyc(20);
      load(0, 1);
      wait_cyc(45);
    end

    // R5, R6: divided clock, every rate, both invert settings
    for (int r = 0; r < 4; r++) begin
      for (int iv = 0; iv < 2; iv++) begin
        tag = $sformatf("R5_R6_rate_%0d_inv_%0d", r, iv);
        do_reset(1, 2'(r), iv[0], 3'(r), 3'(r + 2), iv[0], 1'b1);
        wait_cyc(r + iv);
        load(1, 1);
        wait_cyc((2 << r) * 24);
      end
    end

    // R7: loads while busy, back to back and replaced
    tag = "R7_held_full_rate";
    do_reset(0, 2'd0, 0, 3'd0, 3'd2, 1'b1, 1'b1);
    load(1, 1);
    wait_cyc(2);
    load(1, 0);
    wait_cyc(1);
    load(1, 1);
    wait_cyc(60);
    tag = "R7_held_divided";
    do_reset(1, 2'd1, 1, 3'd1, 3'd0, 1'b0, 1'b1);
    load(1, 1);
    wait_cyc(5);
    load(1, 1);
    wait_cyc(3);
    load(0, 1);
    wait_cyc(4 * 40);

    // R9: load at each divider phase
    for (int ph = 0; ph < 8; ph++) begin
      tag = $sformatf("R9_phase_%0d", ph);
      do_reset(1, 2'd2, 0, 3'd0, 3'd0, 1'b1, 1'b0);
      wait_cyc(ph);
      load(1, ph[0]);
      wait_cyc(8 * 12);
    end

    summary();
  end

endmodule